// File: doc/BRIEF.md
# CPU-Space Cycle Decoder

This block watches the bus of a 32-bit processor and picks out the cycles that run in the processor's own CPU address space. It does not compare an address range. It first checks that the three function-code outputs are all ones. It then reads a four-bit cycle-type field on address lines 19 to 16 to decide which of three cycle kinds is running: a floating-point coprocessor access, an interrupt acknowledge, or a breakpoint acknowledge.

For each recognised kind the block drives one registered strobe. These are an active-low chip select for the coprocessor, an active-low interrupt-acknowledge enable with the three-bit level being acknowledged, and an active-high breakpoint-acknowledge flag. The address strobe frames every output, in the same way it frames an ordinary device select.

A CPU-space cycle with an unknown type field raises nothing. A bus-error timeout elsewhere in the system can then end that cycle. Priority arbitration, vector generation and the coprocessor protocol are left to other logic.

Top module: `cpu_space_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fpu_cs_n` and `iack_n` are 1, `bkpt_ack` is 0 and `iack_level` is 000.
- R2: When `fc` is anything other than 111, no strobe asserts in the next cycle, whatever the address and `rw` are.
- R3: With `as_n`=0, `fc`=111, `addr[19:16]`=0010 and `addr[15:13]` equal to the coprocessor ID parameter (default 001), `fpu_cs_n` is 0 one clock later, for both `rw`=1 and `rw`=0, whatever the other address bits are.
- R4: A coprocessor-type cycle (`addr[19:16]`=0010) whose `addr[15:13]` differs from the coprocessor ID leaves `fpu_cs_n` at 1.
- R5: With `as_n`=0, `fc`=111, `addr[19:16]`=1111 and `rw`=1, `iack_n` is 0 one clock later and `iack_level` equals the `addr[3:1]` sampled at that edge.
- R6: With `as_n`=0, `fc`=111, `addr[19:16]`=0000 and `rw`=1, `bkpt_ack` is 1 one clock later.
- R7: Interrupt-acknowledge and breakpoint-type cycles with `rw`=0 (write) assert no strobe.
- R8: A CPU-space cycle whose type field is any value other than 0000, 0010 or 1111 asserts no strobe.
- R9: When `as_n` is 1 at a clock edge, every strobe is inactive after that edge, even if the other inputs match a cycle type.
- R10: At most one strobe is active at any time, and `iack_level` reads 000 whenever `iack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc | input | 3 | Processor function-code outputs |
| addr | input | ADDR_W (32) | Processor address bus |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| fpu_cs_n | output | 1 | Coprocessor chip select, active low |
| iack_n | output | 1 | Interrupt-acknowledge enable, active low |
| iack_level | output | 3 | Level being acknowledged, valid while `iack_n` is 0 |
| bkpt_ack | output | 1 | Breakpoint-acknowledge flag, active high |

## Verification
Every output passes through exactly one register. A result is therefore due one rising edge after its inputs are set up, and a negated address strobe clears the outputs after the same single edge.

The bench changes inputs on a falling edge. It waits for the next falling edge, so that exactly one rising edge has passed, and compares all four outputs there. Deassertion is checked the same way: the bench first raises a strobe, then negates the address strobe, and after one edge expects every output to be idle.

// File: rtl/cpu_space_pkg.sv
package cpu_space_pkg;

    localparam int FC_W      = 3;
    localparam int TYPE_W    = 4;
    localparam int ID_W      = 3;
    localparam int LVL_W     = 3;

    // Bit positions of the fields inside a CPU-space address
    localparam int TYPE_LSB  = 16;
    localparam int ID_LSB    = 13;
    localparam int LVL_LSB   = 1;

    localparam logic [FC_W-1:0]   FC_CPU_SPACE = '1;
    localparam logic [TYPE_W-1:0] TYPE_BKPT    = 4'h0;
    localparam logic [TYPE_W-1:0] TYPE_COPRO   = 4'h2;
    localparam logic [TYPE_W-1:0] TYPE_IACK    = 4'hF;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_COPRO,
        KIND_IACK,
        KIND_BKPT
    } cyc_kind_e;

    typedef struct packed {
        logic             fpu_cs_n;
        logic             iack_n;
        logic [LVL_W-1:0] level;
        logic             bkpt;
    } strobe_s;

    localparam strobe_s STROBE_IDLE = '{fpu_cs_n: 1'b1, iack_n: 1'b1,
                                        level: '0, bkpt: 1'b0};

endpackage

// File: rtl/cs_space_qual.sv
module cs_space_qual
    import cpu_space_pkg::*;
(
    input  logic [FC_W-1:0] fc,
    input  logic            as_n,
    output logic            in_cpu_space
);
    // A qualifying cycle needs an asserted strobe and the all-ones function code
    always_comb begin
        in_cpu_space = !as_n && (fc == FC_CPU_SPACE);
    end
endmodule

// File: rtl/cs_type_decode.sv
module cs_type_decode
    import cpu_space_pkg::*;
#(
    parameter logic [ID_W-1:0] COPRO_ID = 3'b001
) (
    input  logic [TYPE_W-1:0] type_field,
    input  logic [ID_W-1:0]   id_field,
    input  logic [LVL_W-1:0]  lvl_field,
    input  logic              rw,
    output cyc_kind_e         kind,
    output logic [LVL_W-1:0]  level
);
    always_comb begin
        kind  = KIND_NONE;
        level = '0;
        unique case (type_field)
            TYPE_COPRO: begin
                if (id_field == COPRO_ID) kind = KIND_COPRO;
            end
            TYPE_IACK: begin
                if (rw) begin
                    kind  = KIND_IACK;
                    level = lvl_field;
                end
            end
            TYPE_BKPT: begin
                if (rw) kind = KIND_BKPT;
            end
            default: kind = KIND_NONE;
        endcase
    end
endmodule

// File: rtl/cpu_space_decoder.sv
module cpu_space_decoder
    import cpu_space_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter logic [ID_W-1:0]  COPRO_ID = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FC_W-1:0]   fc,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              rw,
    output logic              fpu_cs_n,
    output logic              iack_n,
    output logic [LVL_W-1:0]  iack_level,
    output logic              bkpt_ack
);
    localparam int TYPE_MSB = TYPE_LSB + TYPE_W - 1;
    localparam int ID_MSB   = ID_LSB + ID_W - 1;
    localparam int LVL_MSB  = LVL_LSB + LVL_W - 1;

    logic         in_space;
    cyc_kind_e    kind;
    logic [LVL_W-1:0] dec_level;
    strobe_s      strb_d, strb_q;

    // Address bits that carry no meaning in a CPU-space cycle
    logic unused_addr;
    assign unused_addr = ^{addr[ADDR_W-1:TYPE_MSB+1], addr[ID_LSB-1:LVL_MSB+1],
                           addr[LVL_LSB-1:0]};

    cs_space_qual u_qual (
        .fc           (fc),
        .as_n         (as_n),
        .in_cpu_space (in_space)
    );

    cs_type_decode #(.COPRO_ID(COPRO_ID)) u_decode (
        .type_field (addr[TYPE_MSB:TYPE_LSB]),
        .id_field   (addr[ID_MSB:ID_LSB]),
        .lvl_field  (addr[LVL_MSB:LVL_LSB]),
        .rw         (rw),
        .kind       (kind),
        .level      (dec_level)
    );

    always_comb begin
        strb_d = STROBE_IDLE;
        if (in_space) begin
            case (kind)
                KIND_COPRO: strb_d.fpu_cs_n = 1'b0;
                KIND_IACK: begin
                    strb_d.iack_n = 1'b0;
                    strb_d.level  = dec_level;
                end
                KIND_BKPT:  strb_d.bkpt = 1'b1;
                default:    strb_d = STROBE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_q <= STROBE_IDLE;
        else        strb_q <= strb_d;
    end

    assign fpu_cs_n   = strb_q.fpu_cs_n;
    assign iack_n     = strb_q.iack_n;
    assign iack_level = strb_q.level;
    assign bkpt_ack   = strb_q.bkpt;

endmodule

// File: rtl/cpu_space_decoder_chk.sv
module cpu_space_decoder_chk
    import cpu_space_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ID_W-1:0] COPRO_ID = 3'b001
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FC_W-1:0]   fc,
    input logic [ADDR_W-1:0] addr,
    input logic              as_n,
    input logic              rw,
    input logic              fpu_cs_n,
    input logic              iack_n,
    input logic [LVL_W-1:0]  iack_level,
    input logic              bkpt_ack
);
    a_r2_outside_space_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fc != 3'b111) |=> (fpu_cs_n && iack_n && !bkpt_ack));

    a_r3_copro_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && fc == 3'b111 && addr[19:16] == 4'h2 && addr[15:13] == COPRO_ID)
        |=> !fpu_cs_n);

    a_r5_iack_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && fc == 3'b111 && addr[19:16] == 4'hF && rw)
        |=> (!iack_n && iack_level == $past(addr[3:1])));

    a_r6_bkpt_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && fc == 3'b111 && addr[19:16] == 4'h0 && rw) |=> bkpt_ack);

    a_r7_write_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[19:16] != 4'h2 && !rw) |=> (iack_n && !bkpt_ack && fpu_cs_n));

    a_r9_strobe_negated: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (fpu_cs_n && iack_n && !bkpt_ack));

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!fpu_cs_n, !iack_n, bkpt_ack}));

    a_r10_level_idle: assert property (@(posedge clk) disable iff (!rst_n)
        iack_n |-> (iack_level == 3'b000));
endmodule

bind cpu_space_decoder cpu_space_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .COPRO_ID (COPRO_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fc         (fc),
    .addr       (addr),
    .as_n       (as_n),
    .rw         (rw),
    .fpu_cs_n   (fpu_cs_n),
    .iack_n     (iack_n),
    .iack_level (iack_level),
    .bkpt_ack   (bkpt_ack)
);

// File: tb/cpu_space_decoder_test.sv
module cpu_space_decoder_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fc = 3'b000;
    logic [31:0] addr = '0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic        fpu_cs_n, iack_n, bkpt_ack;
    logic [2:0]  iack_level;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_space_decoder uut (
        .clk(clk), .rst_n(rst_n), .fc(fc), .addr(addr), .as_n(as_n), .rw(rw),
        .fpu_cs_n(fpu_cs_n), .iack_n(iack_n), .iack_level(iack_level),
        .bkpt_ack(bkpt_ack)
    );

    function automatic logic [31:0] cpu_addr(input logic [11:0] hi, input logic [3:0] typ,
                                             input logic [2:0] id, input logic [8:0] mid,
                                             input logic [2:0] lvl, input logic b0);
        return {hi, typ, id, mid, lvl, b0};
    endfunction

    task automatic expect_out(input string req, input logic e_cs_n, input logic e_iack_n,
                              input logic [2:0] e_lvl, input logic e_bkpt);
        n_checks++;
        if ({fpu_cs_n, iack_n, iack_level, bkpt_ack} !== {e_cs_n, e_iack_n, e_lvl, e_bkpt}) begin
            n_fails++;
            $display("FAIL %s: got cs_n=%b iack_n=%b lvl=%0d bkpt=%b, expected cs_n=%b iack_n=%b lvl=%0d bkpt=%b",
                     req, fpu_cs_n, iack_n, iack_level, bkpt_ack,
                     e_cs_n, e_iack_n, e_lvl, e_bkpt);
        end
    endtask

    // Drive on a falling edge; one rising edge later the result is compared
    task automatic drive(input logic [2:0] f, input logic [31:0] a, input logic s_n,
                         input logic r);
        @(negedge clk);
        fc = f; addr = a; as_n = s_n; rw = r;
        @(negedge clk);
    endtask

    task automatic t_reset();
        fc = 3'b111; addr = cpu_addr(12'h0, 4'h2, 3'b001, 9'h0, 3'd0, 1'b0);
        as_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_out("R1 during reset", 1'b1, 1'b1, 3'd0, 1'b0);
        as_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1'b1, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_outside_space();
        for (int f = 0; f < 7; f++) begin
            drive(3'(f), cpu_addr(12'hABC, 4'hF, 3'b001, 9'h1FF, 3'd5, 1'b1), 1'b0, 1'b1);
            expect_out("R2 iack pattern outside space", 1'b1, 1'b1, 3'd0, 1'b0);
            drive(3'(f), cpu_addr(12'h000, 4'h2, 3'b001, 9'h0, 3'd0, 1'b0), 1'b0, 1'b0);
            expect_out("R2 copro pattern outside space", 1'b1, 1'b1, 3'd0, 1'b0);
        end
    endtask

    task automatic t_copro();
        drive(3'b111, cpu_addr(12'h000, 4'h2, 3'b001, 9'h000, 3'd0, 1'b0), 1'b0, 1'b1);
        expect_out("R3 copro read", 1'b0, 1'b1, 3'd0, 1'b0);
        drive(3'b111, cpu_addr(12'hF5A, 4'h2, 3'b001, 9'h155, 3'd7, 1'b1), 1'b0, 1'b0);
        expect_out("R3 copro write, junk bits", 1'b0, 1'b1, 3'd0, 1'b0);
        drive(3'b111, cpu_addr(12'hF5A, 4'h2, 3'b001, 9'h155, 3'd7, 1'b1), 1'b1, 1'b0);
        expect_out("R9 copro deasserts with strobe", 1'b1, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_bad_id();
        for (int id = 0; id < 8; id++) begin
            if (id == 1) continue;
            drive(3'b111, cpu_addr(12'h0, 4'h2, 3'(id), 9'h0, 3'd0, 1'b0), 1'b0, 1'b1);
            expect_out("R4 foreign coprocessor id", 1'b1, 1'b1, 3'd0, 1'b0);
        end
    endtask

    task automatic t_iack();
        for (int l = 0; l < 8; l++) begin
            drive(3'b111, cpu_addr(12'hFFF, 4'hF, 3'b111, 9'h1FF, 3'(l), 1'b1), 1'b0, 1'b1);
            expect_out("R5 iack level", 1'b1, 1'b0, 3'(l), 1'b0);
        end
        drive(3'b111, cpu_addr(12'hFFF, 4'hF, 3'b111, 9'h1FF, 3'd6, 1'b1), 1'b1, 1'b1);
        expect_out("R9 iack deasserts, R10 level cleared", 1'b1, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_bkpt();
        drive(3'b111, cpu_addr(12'h000, 4'h0, 3'b000, 9'h000, 3'd3, 1'b0), 1'b0, 1'b1);
        expect_out("R6 breakpoint ack", 1'b1, 1'b1, 3'd0, 1'b1);
        drive(3'b111, cpu_addr(12'h000, 4'h0, 3'b000, 9'h000, 3'd3, 1'b0), 1'b1, 1'b1);
        expect_out("R9 breakpoint deasserts", 1'b1, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_write_ack();
        drive(3'b111, cpu_addr(12'hFFF, 4'hF, 3'b111, 9'h1FF, 3'd4, 1'b1), 1'b0, 1'b0);
        expect_out("R7 iack type on write", 1'b1, 1'b1, 3'd0, 1'b0);
        drive(3'b111, cpu_addr(12'h000, 4'h0, 3'b000, 9'h000, 3'd0, 1'b0), 1'b0, 1'b0);
        expect_out("R7 breakpoint type on write", 1'b1, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_other_types();
        for (int t = 0; t < 16; t++) begin
            if (t == 0 || t == 2 || t == 15) continue;
            drive(3'b111, cpu_addr(12'h0, 4'(t), 3'b001, 9'h0, 3'd2, 1'b0), 1'b0, 1'b1);
            expect_out("R8 unmatched type", 1'b1, 1'b1, 3'd0, 1'b0);
        end
    endtask

    task automatic t_strobe_high();
        drive(3'b111, cpu_addr(12'h0, 4'hF, 3'b000, 9'h0, 3'd7, 1'b0), 1'b1, 1'b1);
        expect_out("R9 iack pattern with strobe negated", 1'b1, 1'b1, 3'd0, 1'b0);
        drive(3'b111, cpu_addr(12'h0, 4'h2, 3'b001, 9'h0, 3'd0, 1'b0), 1'b1, 1'b0);
        expect_out("R9 copro pattern with strobe negated", 1'b1, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_back_to_back();
        drive(3'b111, cpu_addr(12'h0, 4'h2, 3'b001, 9'h0, 3'd0, 1'b0), 1'b0, 1'b1);
        expect_out("R10 copro alone", 1'b0, 1'b1, 3'd0, 1'b0);
        drive(3'b111, cpu_addr(12'h0, 4'hF, 3'b000, 9'h0, 3'd3, 1'b0), 1'b0, 1'b1);
        expect_out("R10 switch to iack only", 1'b1, 1'b0, 3'd3, 1'b0);
        drive(3'b111, cpu_addr(12'h0, 4'h0, 3'b000, 9'h0, 3'd3, 1'b0), 1'b0, 1'b1);
        expect_out("R10 switch to breakpoint only", 1'b1, 1'b1, 3'd0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_outside_space();
        t_copro();
        t_bad_id();
        t_iack();
        t_bkpt();
        t_write_ack();
        t_other_types();
        t_strobe_high();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule